// File: doc/BRIEF.md
# Column-Flag Upset Corrector

This controller sits between a user port and a small word-organised memory in which every stored word carries one even-parity bit. Each bit column of the memory, parity column included, has its own upset-detect line, standing in for a current sensor on that column. A pulse on one of these lines sets a sticky latch for the column. Any set latch starts a sweep at once, with no periodic scrub interval. The sweep reads every word and checks its parity. A word whose parity is wrong has the bit in the flagged column inverted and is written back. Words whose parity is correct are not touched.

The column of a single upset comes from the column event. The row comes from the per-word parity. Together they correct one bit while storing only parity. User reads and writes keep working throughout, and they always win the memory port. The sweep moves forward only in cycles with no user request. A status pair reports whether correction work is outstanding and how many words have been rewritten.

The memory itself is outside the block. It is driven through a synchronous port: when `memEn` is high and `memWe` is low, the read data appears on `memRdata` after the next clock edge.

Top module: `col_upset_corrector`

## Requirements
- R1: After reset, `busy` is 0, `corrCount` is 0 and `usrRvalid` is 0.
- R2: A user write stores a 9-bit word: data in bits 7:0 and bit 8 equal to the XOR of the data bits, so every stored word has even parity. A user read returns bits 7:0 on `usrRdata` with `usrRvalid` high one cycle after the request.
- R3: A pulse on any `upsetFlag` bit sets a sticky latch for that column. `busy` is high from the cycle after the pulse, and the sweep starts without waiting for any interval.
- R4: During a sweep for column c, a word read back with odd parity has bit c inverted and is written back. Each such rewrite increments `corrCount` by exactly 1.
- R5: A word read back with even parity is not written by the sweep. A sweep over clean memory leaves `corrCount` unchanged.
- R6: The sweep drives the memory port only in cycles where `usrReq` is low. User reads and writes complete normally while a sweep is stalled.
- R7: A user write to a word before the sweep reaches it stores fresh data and parity, and the sweep does not rewrite that word.
- R8: When several column latches are set, the lowest column is swept first. Each latch clears only after its full sweep over all words, and `busy` falls once no latch is set and no sweep is running.
- R9: A new pulse on the column being swept, arriving during that sweep, keeps its latch set, so a further sweep repairs words already passed.
- R10: A flag on the parity column (bit 8) repairs a flipped stored parity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| usrReq | input | 1 | User access request for this cycle |
| usrWe | input | 1 | User access is a write |
| usrAddr | input | 5 | User word address |
| usrWdata | input | 8 | User write data |
| usrRdata | output | 8 | User read data |
| usrRvalid | output | 1 | `usrRdata` holds the result of the previous cycle's read |
| memEn | output | 1 | Memory access enable |
| memWe | output | 1 | Memory write enable |
| memAddr | output | 5 | Memory word address |
| memWdata | output | 9 | Memory write word, parity in bit 8 |
| memRdata | input | 9 | Memory read word, one cycle after a read |
| upsetFlag | input | 9 | Per-column upset pulses, bit 8 is the parity column |
| busy | output | 1 | A latch is set or a sweep is running |
| corrCount | output | 16 | Number of words rewritten by sweeps |

## Verification
Single upsets are placed in a data column and in the parity column. Each shows that only the flagged bit is inverted and that only the damaged word is rewritten. A flag with no real upset separates "sweep runs" from "sweep writes": `busy` must pulse while no rewrite happens. Sustained user reads during a pending repair show that the sweep stalls without corrupting user data. Two flags raised together, with the damage placed so that only a lowest-column-first order repairs it correctly, pin down the service order. A repeated pulse on a column already mid-sweep shows that its latch survives for a second pass.

// File: rtl/cuc_pkg.sv
package cuc_pkg;

  typedef enum logic [1:0] {
    S_IDLE,
    S_RD,
    S_CHK,
    S_WR
  } sweepState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic sweepRd;     // issue a sweep read this cycle
    logic fixCapture;  // latch the repaired word from read data
    logic fixWrite;    // write the repaired word back
  } ctlStrb_t;

endpackage

// File: rtl/cuc_ctrl.sv
module cuc_ctrl
  import cuc_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int COLS   = 9,
  parameter int COL_W  = $clog2(COLS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              usrReq,
  input  logic              usrWe,
  input  logic [ADDR_W-1:0] usrAddr,
  input  logic [COLS-1:0]   upsetFlag,
  input  logic              parErr,
  output ctlStrb_t          strb,
  output logic [ADDR_W-1:0] sweepAddr,
  output logic [COL_W-1:0]  curCol,
  output logic              busy
);

  sweepState_t      state;
  logic [COLS-1:0]  latch;
  logic [COLS-1:0]  clrMask;
  logic [COL_W-1:0] lowCol;
  logic             rehit;
  logic             userWrHit;
  logic             advance;
  logic             sweepDone;

  always_comb begin
    lowCol = '0;
    for (int i = COLS - 1; i >= 0; i--) begin
      if (latch[i]) lowCol = COL_W'(i);
    end
  end

  assign userWrHit = usrReq && usrWe && (usrAddr == sweepAddr);

  always_comb begin
    strb.sweepRd    = (state == S_RD) && !usrReq;
    strb.fixCapture = (state == S_CHK) && parErr && !userWrHit;
    strb.fixWrite   = (state == S_WR) && !usrReq;
  end

  assign advance   = ((state == S_CHK) && !strb.fixCapture) ||
                     ((state == S_WR) && (userWrHit || !usrReq));
  assign sweepDone = advance && (&sweepAddr);

  always_comb begin
    clrMask = '0;
    if (sweepDone && !rehit) clrMask[curCol] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latch <= '0;
      rehit <= 1'b0;
    end else begin
      latch <= (latch & ~clrMask) | upsetFlag;
      if (sweepDone)
        rehit <= 1'b0;
      else if (state != S_IDLE && upsetFlag[curCol])
        rehit <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      sweepAddr <= '0;
      curCol    <= '0;
    end else begin
      case (state)
        S_IDLE: if (|latch) begin
          curCol    <= lowCol;
          sweepAddr <= '0;
          state     <= S_RD;
        end
        S_RD:  if (strb.sweepRd) state <= S_CHK;
        S_CHK: if (strb.fixCapture) state <= S_WR;
        default: ;
      endcase
      if (advance) begin
        if (&sweepAddr) state <= S_IDLE;
        else begin
          sweepAddr <= sweepAddr + 1'b1;
          state     <= S_RD;
        end
      end
    end
  end

  assign busy = (|latch) || (state != S_IDLE);

  // the column under sweep keeps its latch until the sweep ends
  p_col_latched_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE) |-> latch[curCol]);

  p_busy_after_flag_r3: assert property (@(posedge clk) disable iff (!rstN)
    (|upsetFlag) |=> busy);

endmodule

// File: rtl/cuc_datapath.sv
module cuc_datapath
  import cuc_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int COL_W  = 4,
  parameter int CNT_W  = 16,
  localparam int WORD_W = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              usrReq,
  input  logic              usrWe,
  input  logic [ADDR_W-1:0] usrAddr,
  input  logic [DATA_W-1:0] usrWdata,
  output logic [DATA_W-1:0] usrRdata,
  output logic              usrRvalid,
  input  ctlStrb_t          strb,
  input  logic [ADDR_W-1:0] sweepAddr,
  input  logic [COL_W-1:0]  curCol,
  output logic              parErr,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  input  logic [WORD_W-1:0] memRdata,
  output logic [CNT_W-1:0]  corrCount
);

  logic [WORD_W-1:0] fixWord;

  assign parErr = ^memRdata;

  assign memEn    = usrReq || strb.sweepRd || strb.fixWrite;
  assign memWe    = usrReq ? usrWe : strb.fixWrite;
  assign memAddr  = usrReq ? usrAddr : sweepAddr;
  assign memWdata = usrReq ? {^usrWdata, usrWdata} : fixWord;

  assign usrRdata = memRdata[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fixWord   <= '0;
      corrCount <= '0;
      usrRvalid <= 1'b0;
    end else begin
      usrRvalid <= usrReq && !usrWe;
      if (strb.fixCapture)
        fixWord <= memRdata ^ (WORD_W'(1) << curCol);
      if (strb.fixWrite)
        corrCount <= corrCount + 1'b1;
    end
  end

  p_user_first_r6: assert property (@(posedge clk) disable iff (!rstN)
    usrReq |-> !(strb.sweepRd || strb.fixWrite));

  p_even_parity_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && memWe) |-> (^memWdata == 1'b0));

  p_count_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (corrCount != $past(corrCount)) |-> (corrCount == $past(corrCount) + 1'b1));

endmodule

// File: rtl/col_upset_corrector.sv
module col_upset_corrector
  import cuc_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16,
  localparam int COLS  = DATA_W + 1,
  localparam int COL_W = $clog2(COLS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              usrReq,
  input  logic              usrWe,
  input  logic [ADDR_W-1:0] usrAddr,
  input  logic [DATA_W-1:0] usrWdata,
  output logic [DATA_W-1:0] usrRdata,
  output logic              usrRvalid,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [COLS-1:0]   memWdata,
  input  logic [COLS-1:0]   memRdata,
  input  logic [COLS-1:0]   upsetFlag,
  output logic              busy,
  output logic [CNT_W-1:0]  corrCount
);

  ctlStrb_t          strb;
  logic [ADDR_W-1:0] sweepAddr;
  logic [COL_W-1:0]  curCol;
  logic              parErr;

  cuc_ctrl #(.ADDR_W(ADDR_W), .COLS(COLS), .COL_W(COL_W)) uCtrl (
    .clk(clk), .rstN(rstN), .usrReq(usrReq), .usrWe(usrWe), .usrAddr(usrAddr),
    .upsetFlag(upsetFlag), .parErr(parErr), .strb(strb),
    .sweepAddr(sweepAddr), .curCol(curCol), .busy(busy)
  );

  cuc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COL_W(COL_W), .CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .usrReq(usrReq), .usrWe(usrWe), .usrAddr(usrAddr),
    .usrWdata(usrWdata), .usrRdata(usrRdata), .usrRvalid(usrRvalid),
    .strb(strb), .sweepAddr(sweepAddr), .curCol(curCol), .parErr(parErr),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .corrCount(corrCount)
  );

endmodule

// File: tb/sim_col_upset_corrector.sv
module sim_col_upset_corrector;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       usrReq = 1'b0, usrWe = 1'b0;
  logic [4:0] usrAddr = '0;
  logic [7:0] usrWdata = '0;
  logic [7:0] usrRdata;
  logic       usrRvalid;
  logic       memEn, memWe;
  logic [4:0] memAddr;
  logic [8:0] memWdata;
  logic [8:0] memRdata = '0;
  logic [8:0] upsetFlag = '0;
  logic       busy;
  logic [15:0] corrCount;

  logic [8:0] mem [32];
  logic [7:0] golden [32];
  logic       injReq = 1'b0;
  logic [4:0] injAddr = '0;
  logic [3:0] injCol = '0;
  int         fixN = 0;
  logic [4:0] fixLog [16];
  int checks = 0, errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  col_upset_corrector u0 (
    .clk(clk), .rstN(rstN), .usrReq(usrReq), .usrWe(usrWe), .usrAddr(usrAddr),
    .usrWdata(usrWdata), .usrRdata(usrRdata), .usrRvalid(usrRvalid),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .upsetFlag(upsetFlag), .busy(busy), .corrCount(corrCount)
  );

  // memory model with upset injection and a log of corrector writes
  always @(posedge clk) begin
    if (injReq) mem[injAddr][injCol] <= ~mem[injAddr][injCol];
    if (memEn) begin
      if (memWe) begin
        mem[memAddr] <= memWdata;
        if (!usrReq) begin
          fixLog[fixN[3:0]] <= memAddr;
          fixN <= fixN + 1;
        end
      end else begin
        memRdata <= mem[memAddr];
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] enc(input logic [7:0] d);
    return {^d, d};
  endfunction

  task automatic userWrite(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    usrReq = 1; usrWe = 1; usrAddr = a; usrWdata = d;
    @(negedge clk);
    usrReq = 0; usrWe = 0;
    golden[a] = d;
  endtask

  task automatic userRead(input logic [4:0] a, output logic [7:0] d, output logic v);
    @(negedge clk);
    usrReq = 1; usrWe = 0; usrAddr = a;
    @(negedge clk);
    usrReq = 0;
    d = usrRdata; v = usrRvalid;
  endtask

  task automatic inject(input logic [4:0] a, input logic [3:0] c);
    @(negedge clk);
    injReq = 1; injAddr = a; injCol = c;
    @(negedge clk);
    injReq = 0;
  endtask

  task automatic pulse(input logic [8:0] m);
    @(negedge clk);
    upsetFlag = m;
    @(negedge clk);
    upsetFlag = '0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 3000; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk(busy == 0, "R1 busy", busy, 0);
    chk(corrCount == 0, "R1 corrCount", corrCount, 0);
    chk(usrRvalid == 0, "R1 usrRvalid", usrRvalid, 0);
  endtask

  task automatic t_user_rw();
    logic [7:0] d; logic v;
    for (int i = 0; i < 32; i++) userWrite(5'(i), 8'(i * 37 + 11));
    userWrite(5, 8'hA5);
    @(negedge clk);
    chk(mem[5] == enc(8'hA5), "R2 stored word", mem[5], enc(8'hA5));
    userRead(5, d, v);
    chk(v == 1, "R2 read valid", v, 1);
    chk(d == 8'hA5, "R2 read data", d, 8'hA5);
    userRead(6, d, v);
    chk(d == golden[6], "R2 read data2", d, golden[6]);
  endtask

  task automatic t_single_fix();
    int n0 = fixN; int c0 = corrCount;
    inject(7, 3);
    pulse(9'h008);
    chk(busy == 1, "R3 busy after pulse", busy, 1);
    waitIdle();
    chk(mem[7] == enc(golden[7]), "R4 word repaired", mem[7], enc(golden[7]));
    chk(fixN - n0 == 1, "R4 single rewrite", fixN - n0, 1);
    chk(fixLog[n0[3:0]] == 7, "R4 rewrite address", fixLog[n0[3:0]], 7);
    chk(corrCount == c0 + 1, "R4 count", corrCount, c0 + 1);
  endtask

  task automatic t_parity_col();
    int c0 = corrCount;
    inject(30, 8);
    pulse(9'h100);
    waitIdle();
    chk(mem[30] == enc(golden[30]), "R10 parity repaired", mem[30], enc(golden[30]));
    chk(corrCount == c0 + 1, "R10 count", corrCount, c0 + 1);
  endtask

  task automatic t_clean_sweep();
    int n0 = fixN; int c0 = corrCount;
    pulse(9'h010);
    chk(busy == 1, "R5 sweep runs", busy, 1);
    waitIdle();
    chk(busy == 0, "R5 sweep ends", busy, 0);
    chk(fixN == n0, "R5 no rewrite", fixN - n0, 0);
    chk(corrCount == c0, "R5 count steady", corrCount, c0);
  endtask

  task automatic t_priority();
    int n0 = fixN; bit readOk = 1; bit validOk = 1;
    inject(12, 1);
    pulse(9'h002);
    @(negedge clk);
    usrReq = 1; usrWe = 0; usrAddr = 4;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (usrRdata != golden[4]) readOk = 0;
      if (!usrRvalid) validOk = 0;
    end
    usrReq = 0;
    chk(readOk, "R6 user reads correct", 0, 0);
    chk(validOk, "R6 user reads valid", 0, 0);
    chk(fixN == n0, "R6 sweep stalled", fixN - n0, 0);
    chk(busy == 1, "R6 busy while stalled", busy, 1);
    waitIdle();
    chk(mem[12] == enc(golden[12]), "R6 repaired after stall", mem[12], enc(golden[12]));
  endtask

  task automatic t_user_overwrite();
    int n0 = fixN;
    inject(25, 0);
    pulse(9'h001);
    userWrite(25, 8'h3C);
    waitIdle();
    chk(mem[25] == enc(8'h3C), "R7 fresh data kept", mem[25], enc(8'h3C));
    chk(fixN == n0, "R7 no rewrite", fixN - n0, 0);
  endtask

  task automatic t_order();
    int n0 = fixN;
    pulse(9'h024);  // columns 2 and 5 together
    repeat (80) @(negedge clk);
    chk(busy == 1, "R8 second sweep running", busy, 1);
    inject(20, 5);
    waitIdle();
    chk(mem[20] == enc(golden[20]), "R8 lowest column first", mem[20], enc(golden[20]));
    chk(fixN - n0 == 1, "R8 one rewrite", fixN - n0, 1);
    chk(busy == 0, "R8 all latches clear", busy, 0);
  endtask

  task automatic t_rehit();
    int n0 = fixN;
    pulse(9'h040);
    repeat (20) @(negedge clk);
    inject(2, 6);
    pulse(9'h040);
    waitIdle();
    chk(mem[2] == enc(golden[2]), "R9 second pass repairs", mem[2], enc(golden[2]));
    chk(fixN - n0 == 1, "R9 one rewrite", fixN - n0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_user_rw();
    t_single_fix();
    t_parity_col();
    t_clean_sweep();
    t_priority();
    t_user_overwrite();
    t_order();
    t_rehit();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule